// File: doc/BRIEF.md
# Interlocked Read Handshake over a Shared Address/Data Bus

This block carries single-word reads between an I/O-side requester and a memory-side responder over one set of shared lines with no common timing reference. The address and then the returned word travel on the same lines, one after the other. Three control wires, a request strobe, an acknowledge and a data-ready strobe, sequence the transfer through two fully interlocked handshakes: request/acknowledge for the address, then data-ready/acknowledge for the word. Each side acts only after it has seen the other side's control change through its own two-flop synchronizer.

The requester takes a command (address plus a valid strobe) when it is ready and returns the word with a one-cycle valid pulse. The responder fronts a small synchronous memory with a write port and a configurable access delay. The shared lines are modelled as a resolved bus. Each side has its own output enable, and an undriven bus reads as zero. The acknowledge wire is the OR of both sides' drivers.

Top module: `hshk_read_link`

## Requirements
- R1: After a command is accepted, the requester raises the request strobe and drives the address onto the bus, zero-extended into the upper bus bits. The bus value does not change while the request strobe stays high.
- R2: At most one side drives the bus in any cycle. When neither side drives it, the bus reads as all zeros.
- R3: The responder raises the acknowledge only after it sees the request strobe high. The requester lowers the request strobe and stops driving the bus only after it sees the acknowledge high.
- R4: The responder lowers its acknowledge only after it sees the request strobe low.
- R5: Data-ready rises only while the acknowledge is low. It rises no earlier than ACCESS_DLY+1 cycles after the acknowledge rose for the address. When the access delay is the binding limit (ACCESS_DLY=12), the gap is exactly ACCESS_DLY+1 cycles.
- R6: While data-ready is high, the bus carries the memory word at the captured address. The requester returns that word on the read data output with a valid pulse that lasts one cycle.
- R7: The requester raises the acknowledge after it sees data-ready high. The responder then drops data-ready and releases the bus. The requester lowers the acknowledge only after it sees data-ready low.
- R8: The command-ready output is high only when the requester is idle and the acknowledge it observes is low. A command offered while ready is low is ignored.
- R9: After reset, all three control wires are low, the bus is undriven (zero), the read-valid output is low and command-ready is high.
- R10: A write on the memory write port replaces the word at that address, and later reads return the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Read command offered |
| cmdAddr | input | ADDR_W | Address of the read command |
| cmdReady | output | 1 | Requester can take a command |
| rspValid | output | 1 | One-cycle pulse: read word available |
| rspData | output | DATA_W | Returned read word |
| memWrEn | input | 1 | Memory write strobe |
| memWrAddr | input | ADDR_W | Memory write address |
| memWrData | input | DATA_W | Memory write word |
| busReadReq | output | 1 | Request strobe on the link |
| busAck | output | 1 | Resolved acknowledge (OR of both drivers) |
| busDataRdy | output | 1 | Data-ready strobe on the link |
| busLines | output | DATA_W | Resolved shared address/data lines |
| reqDriving | output | 1 | Requester output enable on the bus |
| rspDriving | output | 1 | Responder output enable on the bus |

## Verification
The hardest situation to reach is the one where the responder's own acknowledge echo is still in its synchronizer while data-ready is about to rise. A weak ordering would then mistake that stale echo for the requester's data acknowledge. The bench runs two instances side by side on the same stimulus. One has a short access delay, so the handshake path alone sets the data-ready time and the echo wait is exercised. The other has a long delay, so the delay counter sets the time and the gap can be checked exactly. Every address is read under two memory patterns. Extra commands are injected while a read is in flight.

// File: rtl/hshk_pkg.sv
package hshk_pkg;

  typedef enum logic [1:0] {
    RQ_IDLE,
    RQ_ADDR,
    RQ_WAIT_DATA,
    RQ_ACK_DATA
  } reqState_t;

  typedef enum logic [2:0] {
    RS_IDLE,
    RS_ACK_ADDR,
    RS_ACCESS,
    RS_PRESENT,
    RS_WAIT_ACK_LOW
  } rspState_t;

  typedef struct packed {
    logic latchAddr;
    logic captureData;
    logic finish;
  } reqStrobe_t;

  typedef struct packed {
    logic captureAddr;
    logic loadData;
  } rspStrobe_t;

endpackage

// File: rtl/hshk_sync.sv
module hshk_sync #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end

endmodule

// File: rtl/hshk_requester.sv
module hshk_requester
  import hshk_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [ADDR_W-1:0] cmdAddr,
  output logic              cmdReady,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  input  logic [DATA_W-1:0] busIn,
  input  logic              ackIn,
  input  logic              dataRdyIn,
  output logic              readReqOut,
  output logic              ackOut,
  output logic              busOe,
  output logic [DATA_W-1:0] busDrv
);

  logic [1:0] ctlSync;
  logic       ackS;
  logic       dataRdyS;

  hshk_sync #(.WIDTH(2)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({ackIn, dataRdyIn}),
    .dout (ctlSync)
  );
  assign {ackS, dataRdyS} = ctlSync;

  reqState_t        state, stateNxt;
  reqStrobe_t       stb;
  logic [ADDR_W-1:0] addrReg;

  // control
  always_comb begin
    stateNxt = state;
    stb      = '0;
    case (state)
      RQ_IDLE:
        if (cmdValid && !ackS) begin
          stb.latchAddr = 1'b1;
          stateNxt      = RQ_ADDR;
        end
      RQ_ADDR:
        if (ackS) stateNxt = RQ_WAIT_DATA;
      RQ_WAIT_DATA:
        if (dataRdyS) begin
          stb.captureData = 1'b1;
          stateNxt        = RQ_ACK_DATA;
        end
      RQ_ACK_DATA:
        if (!dataRdyS) begin
          stb.finish = 1'b1;
          stateNxt   = RQ_IDLE;
        end
      default: stateNxt = RQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= RQ_IDLE;
    else       state <= stateNxt;
  end

  // datapath
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg  <= '0;
      rspData  <= '0;
      rspValid <= 1'b0;
    end else begin
      if (stb.latchAddr)   addrReg <= cmdAddr;
      if (stb.captureData) rspData <= busIn;
      rspValid <= stb.finish;
    end
  end

  assign cmdReady   = (state == RQ_IDLE) && !ackS;
  assign readReqOut = (state == RQ_ADDR);
  assign busOe      = (state == RQ_ADDR);
  assign busDrv     = DATA_W'(addrReg);
  assign ackOut     = (state == RQ_ACK_DATA);

  AST_REQ_HOLDS_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (readReqOut && !ackS) |=> readReqOut); // R3
  AST_REQ_DROPS_AFTER_ACK: assert property (@(posedge clk) disable iff (!rstN)
    $fell(readReqOut) |-> ($past(ackS) && !busOe)); // R3
  AST_ACK_AFTER_DATA_RDY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackOut) |-> $past(dataRdyS)); // R7
  AST_ACK_DROPS_AFTER_RDY_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ackOut) |-> !$past(dataRdyS)); // R7
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid); // R6
  AST_CMD_ONLY_WHEN_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(readReqOut) |-> !$past(ackS)); // R8

endmodule

// File: rtl/hshk_responder.sv
module hshk_responder
  import hshk_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 8,
  parameter int ACCESS_DLY = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] busIn,
  input  logic              readReqIn,
  input  logic              ackIn,
  input  logic              memWrEn,
  input  logic [ADDR_W-1:0] memWrAddr,
  input  logic [DATA_W-1:0] memWrData,
  output logic              ackOut,
  output logic              dataRdyOut,
  output logic              busOe,
  output logic [DATA_W-1:0] busDrv
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = $clog2(ACCESS_DLY + 1) + 1;

  logic [1:0] ctlSync;
  logic       readReqS;
  logic       ackS;

  hshk_sync #(.WIDTH(2)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({readReqIn, ackIn}),
    .dout (ctlSync)
  );
  assign {readReqS, ackS} = ctlSync;

  rspState_t         state, stateNxt;
  rspStrobe_t        stb;
  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] memQ;
  logic [DATA_W-1:0] dataReg;
  logic [CNT_W-1:0]  cnt;
  logic              delayDone;
  logic [DATA_W-1:0] mem [DEPTH];

  assign delayDone = (cnt >= CNT_W'(ACCESS_DLY));

  // control
  always_comb begin
    stateNxt = state;
    stb      = '0;
    case (state)
      RS_IDLE:
        if (readReqS) begin
          stb.captureAddr = 1'b1;
          stateNxt        = RS_ACK_ADDR;
        end
      RS_ACK_ADDR:
        if (!readReqS) stateNxt = RS_ACCESS;
      RS_ACCESS:
        if (!ackS && delayDone) begin
          stb.loadData = 1'b1;
          stateNxt     = RS_PRESENT;
        end
      RS_PRESENT:
        if (ackS) stateNxt = RS_WAIT_ACK_LOW;
      RS_WAIT_ACK_LOW:
        if (!ackS) stateNxt = RS_IDLE;
      default: stateNxt = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= RS_IDLE;
    else       state <= stateNxt;
  end

  // datapath
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      dataReg <= '0;
      cnt     <= '0;
    end else begin
      if (stb.captureAddr) addrReg <= busIn[ADDR_W-1:0];
      if (stb.loadData)    dataReg <= memQ;
      if (stb.captureAddr)  cnt <= '0;
      else if (!delayDone)  cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (memWrEn) mem[memWrAddr] <= memWrData;
    memQ <= mem[addrReg];
  end

  assign ackOut     = (state == RS_ACK_ADDR);
  assign dataRdyOut = (state == RS_PRESENT);
  assign busOe      = (state == RS_PRESENT);
  assign busDrv     = dataReg;

  generate
    if (DATA_W > ADDR_W) begin : g_upper
      AST_ADDR_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
        stb.captureAddr |-> (busIn[DATA_W-1:ADDR_W] == '0)); // R1
    end
  endgenerate

  AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackOut) |-> $past(readReqS)); // R3
  AST_ACK_DROPS_AFTER_REQ_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ackOut) |-> !$past(readReqS)); // R4
  AST_RDY_WITH_ACK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataRdyOut) |-> (!ackOut && !$past(ackS))); // R5
  AST_RDY_NOT_EARLY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataRdyOut) |-> ($past(cnt) >= CNT_W'(ACCESS_DLY))); // R5
  AST_RELEASE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dataRdyOut) |-> ($past(ackS) && !busOe)); // R7

endmodule

// File: rtl/hshk_read_link.sv
module hshk_read_link
  import hshk_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 8,
  parameter int ACCESS_DLY = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [ADDR_W-1:0] cmdAddr,
  output logic              cmdReady,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  input  logic              memWrEn,
  input  logic [ADDR_W-1:0] memWrAddr,
  input  logic [DATA_W-1:0] memWrData,
  output logic              busReadReq,
  output logic              busAck,
  output logic              busDataRdy,
  output logic [DATA_W-1:0] busLines,
  output logic              reqDriving,
  output logic              rspDriving
);

  logic              ackFromReq;
  logic              ackFromRsp;
  logic [DATA_W-1:0] reqDrv;
  logic [DATA_W-1:0] rspDrv;

  hshk_requester #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_requester (
    .clk        (clk),
    .rstN       (rstN),
    .cmdValid   (cmdValid),
    .cmdAddr    (cmdAddr),
    .cmdReady   (cmdReady),
    .rspValid   (rspValid),
    .rspData    (rspData),
    .busIn      (busLines),
    .ackIn      (busAck),
    .dataRdyIn  (busDataRdy),
    .readReqOut (busReadReq),
    .ackOut     (ackFromReq),
    .busOe      (reqDriving),
    .busDrv     (reqDrv)
  );

  hshk_responder #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .ACCESS_DLY (ACCESS_DLY)
  ) u_responder (
    .clk        (clk),
    .rstN       (rstN),
    .busIn      (busLines),
    .readReqIn  (busReadReq),
    .ackIn      (busAck),
    .memWrEn    (memWrEn),
    .memWrAddr  (memWrAddr),
    .memWrData  (memWrData),
    .ackOut     (ackFromRsp),
    .dataRdyOut (busDataRdy),
    .busOe      (rspDriving),
    .busDrv     (rspDrv)
  );

  // resolved shared lines and acknowledge
  assign busLines = (reqDriving ? reqDrv : '0) | (rspDriving ? rspDrv : '0);
  assign busAck   = ackFromReq | ackFromRsp;

  AST_SINGLE_DRIVER: assert property (@(posedge clk) disable iff (!rstN)
    !(reqDriving && rspDriving)); // R2
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (busReadReq && $past(busReadReq)) |-> $stable(busLines)); // R1
  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (busDataRdy && $past(busDataRdy)) |-> $stable(busLines)); // R6

endmodule

// File: tb/test_hshk_read_link.sv
module test_hshk_read_link;

  localparam int AW   = 4;
  localparam int DW   = 8;
  localparam int NDUT = 2;
  localparam int NADR = 1 << AW;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rstN;
  logic          cmdValid   [NDUT];
  logic [AW-1:0] cmdAddr    [NDUT];
  logic          cmdReady   [NDUT];
  logic          rspValid   [NDUT];
  logic [DW-1:0] rspData    [NDUT];
  logic          busReadReq [NDUT];
  logic          busAck     [NDUT];
  logic          busDataRdy [NDUT];
  logic [DW-1:0] busLines   [NDUT];
  logic          reqDriving [NDUT];
  logic          rspDriving [NDUT];
  logic          memWrEn;
  logic [AW-1:0] memWrAddr;
  logic [DW-1:0] memWrData;

  int          pattern;
  int          curAddr [NDUT];
  int          nChk;
  int          nBad;
  bit          finished;

  function automatic logic [DW-1:0] expData(int pat, int a);
    if (pat == 0) return DW'(a * 37 + 5);
    return DW'((a * 11) ^ 165);
  endfunction

  function automatic logic [2:0] stepTuple(int s);
    case (s)
      0: return 3'b100;
      1: return 3'b110;
      2: return 3'b010;
      3: return 3'b000;
      4: return 3'b001;
      5: return 3'b011;
      6: return 3'b010;
      default: return 3'b000;
    endcase
  endfunction

  function automatic string stepTag(int s);
    case (s)
      0: return "R1";
      1: return "R3";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      default: return "R7";
    endcase
  endfunction

  for (genvar g = 0; g < NDUT; g++) begin : g_dut
    localparam int DLY = (g == 0) ? 2 : 12;

    hshk_read_link #(
      .ADDR_W     (AW),
      .DATA_W     (DW),
      .ACCESS_DLY (DLY)
    ) i_hshk_read_link (
      .clk        (clk),
      .rstN       (rstN),
      .cmdValid   (cmdValid[g]),
      .cmdAddr    (cmdAddr[g]),
      .cmdReady   (cmdReady[g]),
      .rspValid   (rspValid[g]),
      .rspData    (rspData[g]),
      .memWrEn    (memWrEn),
      .memWrAddr  (memWrAddr),
      .memWrData  (memWrData),
      .busReadReq (busReadReq[g]),
      .busAck     (busAck[g]),
      .busDataRdy (busDataRdy[g]),
      .busLines   (busLines[g]),
      .reqDriving (reqDriving[g]),
      .rspDriving (rspDriving[g])
    );

    int   mChk = 0;
    int   mBad = 0;
    int   step = 0;
    int   cyc  = 0;
    int   ackRiseCyc = 0;
    logic [2:0] prevCtl = 3'b000;

    always @(negedge clk) begin
      if (!rstN) begin
        step    = 0;
        prevCtl = 3'b000;
      end else begin
        logic [2:0] ctl;
        ctl = {busReadReq[g], busAck[g], busDataRdy[g]};
        cyc++;
        if (ctl != prevCtl) begin
          mChk++;
          if (ctl != stepTuple(step)) begin
            mBad++;
            $display("FAIL %s dut%0d: control rr/ack/rdy actual=%b expected=%b",
                     stepTag(step), g, ctl, stepTuple(step));
          end
          if (step == 1) ackRiseCyc = cyc;
          if (step == 4) begin
            // R5: gap from address ack rise to data-ready rise
            mChk++;
            if ((g == 0 && (cyc - ackRiseCyc) < DLY + 1) ||
                (g == 1 && (cyc - ackRiseCyc) != DLY + 1)) begin
              mBad++;
              $display("FAIL R5 dut%0d: ack-to-ready gap actual=%0d expected=%s%0d",
                       g, cyc - ackRiseCyc, (g == 0) ? ">=" : "", DLY + 1);
            end
          end
          step = (step + 1) % 8;
          prevCtl = ctl;
        end
        mChk++;
        if (reqDriving[g] && rspDriving[g]) begin
          mBad++;
          $display("FAIL R2 dut%0d: drivers actual=2 expected<=1", g);
        end
        if (!reqDriving[g] && !rspDriving[g] && busLines[g] != '0) begin
          mChk++;
          mBad++;
          $display("FAIL R2 dut%0d: idle bus actual=%h expected=00", g, busLines[g]);
        end
        if (busReadReq[g]) begin
          mChk++;
          if (busLines[g] != DW'(curAddr[g])) begin
            mBad++;
            $display("FAIL R1 dut%0d: address on bus actual=%h expected=%h",
                     g, busLines[g], DW'(curAddr[g]));
          end
        end
        if (busDataRdy[g]) begin
          mChk++;
          if (busLines[g] != expData(pattern, curAddr[g])) begin
            mBad++;
            $display("FAIL R6 dut%0d: data on bus actual=%h expected=%h",
                     g, busLines[g], expData(pattern, curAddr[g]));
          end
        end
      end
    end
  end

  task automatic check(bit ok, string tag, string what, int act, int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic doRead(int i, int a, bit inject);
    while (!cmdReady[i]) @(negedge clk);
    curAddr[i]  = a;
    cmdAddr[i]  = AW'(a);
    cmdValid[i] = 1'b1;
    @(negedge clk);
    cmdValid[i] = 1'b0;
    if (inject) begin
      // R8: command offered while busy must be ignored
      cmdAddr[i]  = AW'(~a);
      cmdValid[i] = 1'b1;
      for (int k = 0; k < 2; k++) begin
        check(cmdReady[i] == 1'b0, "R8", "cmdReady while busy", int'(cmdReady[i]), 0);
        @(negedge clk);
      end
      cmdValid[i] = 1'b0;
    end
    while (!rspValid[i]) @(negedge clk);
    check(rspData[i] == expData(pattern, a), (pattern == 1) ? "R10" : "R6",
          "returned word", int'(rspData[i]), int'(expData(pattern, a)));
    @(negedge clk);
    check(rspValid[i] == 1'b0, "R6", "valid pulse length", int'(rspValid[i]), 0);
  endtask

  task automatic report();
    int tot;
    int bad;
    tot = nChk + g_dut[0].mChk + g_dut[1].mChk;
    bad = nBad + g_dut[0].mBad + g_dut[1].mBad;
    $display("test done: total=%0d bad=%0d", tot, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChk++;
      nBad++;
      $display("FAIL R6: watchdog actual=hung expected=complete");
      report();
      $finish;
    end
  end

  initial begin
    finished  = 1'b0;
    nChk      = 0;
    nBad      = 0;
    pattern   = 0;
    rstN      = 1'b0;
    memWrEn   = 1'b0;
    memWrAddr = '0;
    memWrData = '0;
    for (int i = 0; i < NDUT; i++) begin
      cmdValid[i] = 1'b0;
      cmdAddr[i]  = '0;
      curAddr[i]  = 0;
    end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R9: reset state at the ports
    for (int i = 0; i < NDUT; i++) begin
      check(cmdReady[i] == 1'b1, "R9", "cmdReady", int'(cmdReady[i]), 1);
      check({busReadReq[i], busAck[i], busDataRdy[i]} == 3'b000, "R9", "control wires",
            int'({busReadReq[i], busAck[i], busDataRdy[i]}), 0);
      check(busLines[i] == '0, "R9", "bus value", int'(busLines[i]), 0);
      check(rspValid[i] == 1'b0, "R9", "rspValid", int'(rspValid[i]), 0);
    end

    for (int pat = 0; pat < 2; pat++) begin
      pattern = pat;
      // R10: load memory through the write port
      for (int a = 0; a < NADR; a++) begin
        memWrEn   = 1'b1;
        memWrAddr = AW'(a);
        memWrData = expData(pat, a);
        @(negedge clk);
      end
      memWrEn = 1'b0;
      @(negedge clk);
      for (int n = 0; n < NADR; n++) begin
        int a;
        bit inj;
        a   = (pat == 0) ? n : NADR - 1 - n;
        inj = (n % 4) == 1;
        fork
          doRead(0, a, inj);
          doRead(1, a, inj);
        join
      end
    end

    repeat (6) @(negedge clk);
    for (int i = 0; i < NDUT; i++)
      check(cmdReady[i] == 1'b1, "R8", "ready after final read", int'(cmdReady[i]), 1);

    finished = 1'b1;
    report();
    $finish;
  end

endmodule